// File: doc/BRIEF.md
# Lockable Set-Associative Data Cache

This block is a blocking data cache between a CPU load/store port and a word-wide memory port. It has four ways, 32-byte lines, 64 sets and 32-bit words. All transfers are whole, word-aligned 32-bit words, and the two low address bits are ignored. A mode input selects copy-back or write-through handling of stores. An enable input turns off all cache use, and the tag state is then left alone.

Each line has a lock bit. A lock keeps that line from being chosen as a replacement victim, and a locked line can still hit. Lock bits are written through a small side port that names a set, a way and the new bit value. Addresses from 0xFEFF0000 up to 0xFFFFFFFF are never cached.

The CPU raises a request and holds it until `cpu_stall` is low. A hit completes in the cycle it is presented. Any access that needs memory stalls until its memory sequence has finished. The memory port moves one word for each valid/ready handshake.

Top module: `lkcache`

## Requirements
- R1: After reset, with no CPU request, `cpu_stall` and `mem_valid` are both low.
- R2: While `cache_on` is low, a load makes exactly one memory read and a store makes exactly one memory write. Cached lines are neither looked up nor changed, so a later enabled access to a line that was resident still hits.
- R3: An address whose upper 16 bits are 0xFEFF or higher is handled as in R2, even when the cache is enabled.
- R4: A read miss that has a victim way refills all 8 words of the line. The refill starts at the line-aligned address and steps up by 4 bytes each word. The load then returns the refilled word, and later reads of the line hit with no memory traffic.
- R5: In copy-back mode, a store hit writes only the cache line and marks it dirty. There is no memory traffic, and memory keeps the old value.
- R6: In copy-back mode, a store miss that has a victim refills the line first and then completes as a store hit.
- R7: In write-through mode, every store makes exactly one memory write. A store hit also updates the line and clears its dirty bit, and a store miss allocates no line.
- R8: Before a refill, a victim that is both valid and dirty is written back as 8 word writes, but only in copy-back mode. In write-through mode such a victim is dropped without any writes.
- R9: The victim is the lowest-numbered invalid unlocked way. If all unlocked ways are valid, the victim is the least recently used unlocked way. Every hit, and every access completed after a refill, makes its way the most recently used.
- R10: A locked way is never a victim. When all four ways of the set are locked, a miss goes to memory as a single word read or write and allocates nothing.
- R11: A cycle with `lk_we` high sets the lock bit of way `lk_way` in set `lk_set` to `lk_val`.
- R12: A memory request holds its address and direction until `mem_ready`. Memory traffic happens only while `cpu_stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_on | input | 1 | Cache enable; when low, every access bypasses the cache |
| copy_back | input | 1 | 1 = copy-back mode, 0 = write-through mode |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (bits 1:0 ignored) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the cycle a load completes |
| cpu_stall | output | 1 | High while the access cannot complete yet |
| lk_we | input | 1 | Lock bit write strobe |
| lk_set | input | 6 | Set index for the lock write |
| lk_way | input | 2 | Way for the lock write |
| lk_val | input | 1 | New lock bit value |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The assertions take three things for granted:
- The CPU holds its request, address, data and direction stable while `cpu_stall` is high.
- `cache_on` and `copy_back` change only between accesses.
- Memory read data is valid in the same cycle as `mem_ready`.

The bench keeps to these rules in several ways. Each access runs in one task that drives the request and holds it until the stall drops. Mode changes and lock writes happen only between accesses. The memory responder returns data in the handshake cycle after a random number of wait cycles. Random addresses are drawn from a few tags over two sets, so that conflicts, evictions and lock-outs happen often.

// File: rtl/lkcache.sv
module lkcache #(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  parameter int LINE_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_on,
  input  logic        copy_back,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  input  logic        lk_we,
  input  logic [5:0]  lk_set,
  input  logic [1:0]  lk_way,
  input  logic        lk_val,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  localparam int LW = LINE_BYTES / 4;
  localparam int WB = $clog2(LW);
  localparam int SB = $clog2(SETS);
  localparam int AB = $clog2(WAYS);
  localparam int TB = 32 - SB - WB - 2;

  typedef enum logic [2:0] {IDLE, BYP_RD, BYP_WR, WBACK, FILL, DONE} st_t;
  st_t st;

  logic [31:0]   dat [WAYS*SETS*LW];
  logic [TB-1:0] tg  [WAYS*SETS];
  logic [AB-1:0] age [WAYS*SETS];
  logic          vld [WAYS*SETS];
  logic          drt [WAYS*SETS];
  logic          lck [WAYS*SETS];

  logic [31:0]   ra, wd, held;
  logic [AB-1:0] vw, hw, vic;
  logic [WB-1:0] cnt;
  logic          hit, have_vic;

  wire [SB-1:0] ix  = cpu_addr[WB+2 +: SB];
  wire [TB-1:0] at  = cpu_addr[31 -: TB];
  wire [WB-1:0] wo  = cpu_addr[2 +: WB];
  wire [SB-1:0] rix = ra[WB+2 +: SB];
  wire          byp = !cache_on || cpu_addr[31:16] >= 16'hFEFF;
  wire          quick = st == IDLE && cpu_req && !byp && hit && (!cpu_we || copy_back);
  wire          at_idle = st == IDLE;
  wire          in_burst = st == WBACK || st == FILL;

  always_comb begin
    hit = 1'b0; hw = '0; have_vic = 1'b0; vic = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[{AB'(w), ix}] && tg[{AB'(w), ix}] == at) begin
        hit = 1'b1; hw = AB'(w);
      end
      if (!lck[{AB'(w), ix}] && (!have_vic || (vld[{vic, ix}] &&
          (!vld[{AB'(w), ix}] || age[{AB'(w), ix}] > age[{vic, ix}])))) begin
        have_vic = 1'b1; vic = AB'(w);
      end
    end
  end

  assign cpu_stall = st != DONE && (st != IDLE || (cpu_req && !quick));
  assign cpu_rdata = st == DONE ? held : dat[{hw, ix, wo}];
  assign mem_valid = st == BYP_RD || st == BYP_WR || in_burst;
  assign mem_we    = st == BYP_WR || st == WBACK;
  assign mem_wdata = st == WBACK ? dat[{vw, rix, cnt}] : wd;

  always_comb begin
    case (st)
      WBACK:   mem_addr = {tg[{vw, rix}], rix, cnt, 2'b00};
      FILL:    mem_addr = {ra[31 -: TB], rix, cnt, 2'b00};
      default: mem_addr = {ra[31:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; vw <= '0; ra <= '0; wd <= '0; held <= '0;
      for (int i = 0; i < WAYS*SETS; i++) begin
        vld[i] <= 1'b0; drt[i] <= 1'b0; lck[i] <= 1'b0;
        age[i] <= AB'(i / SETS);
      end
    end else begin
      if (lk_we) lck[{lk_way, lk_set}] <= lk_val;
      case (st)
        IDLE: if (cpu_req) begin
          ra <= cpu_addr; wd <= cpu_wdata; cnt <= '0;
          if (byp) st <= cpu_we ? BYP_WR : BYP_RD;
          else if (hit) begin
            for (int u = 0; u < WAYS; u++)
              if (age[{AB'(u), ix}] < age[{hw, ix}]) age[{AB'(u), ix}] <= age[{AB'(u), ix}] + 1'b1;
            age[{hw, ix}] <= '0;
            if (cpu_we) begin
              dat[{hw, ix, wo}] <= cpu_wdata;
              drt[{hw, ix}] <= copy_back;
              if (!copy_back) st <= BYP_WR;
            end
          end else if (cpu_we && (!copy_back || !have_vic)) st <= BYP_WR;
          else if (!have_vic) st <= BYP_RD;
          else begin
            vw <= vic;
            st <= (copy_back && vld[{vic, ix}] && drt[{vic, ix}]) ? WBACK : FILL;
          end
        end
        BYP_RD: if (mem_ready) begin held <= mem_rdata; st <= DONE; end
        BYP_WR: if (mem_ready) st <= DONE;
        WBACK: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == WB'(LW-1)) st <= FILL;
        end
        FILL: if (mem_ready) begin
          dat[{vw, rix, cnt}] <= mem_rdata;
          cnt <= cnt + 1'b1;
          if (cnt == WB'(LW-1)) begin
            tg[{vw, rix}] <= ra[31 -: TB];
            vld[{vw, rix}] <= 1'b1;
            drt[{vw, rix}] <= 1'b0;
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lkcache_chk.sv
module lkcache_chk #(parameter int OB = 3) (
  input logic        clk,
  input logic        rst_n,
  input logic        cache_on,
  input logic        cpu_req,
  input logic [31:0] cpu_addr,
  input logic        cpu_stall,
  input logic        mem_valid,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ready,
  input logic        at_idle,
  input logic        in_burst
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req && at_idle |-> !cpu_stall && !mem_valid);

  assert_off_goes_to_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_idle && cpu_req && !cache_on |-> cpu_stall);

  assert_uncached_goes_to_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    at_idle && cpu_req && cpu_addr[31:16] >= 16'hFEFF |-> cpu_stall);

  assert_burst_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && in_burst && mem_addr[2 +: OB] != {OB{1'b1}}
    |=> mem_valid && mem_addr[2 +: OB] == $past(mem_addr[2 +: OB]) + 1'b1);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

  assert_mem_only_when_stalled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> cpu_stall);
endmodule

bind lkcache lkcache_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cache_on(cache_on), .cpu_req(cpu_req),
  .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .mem_valid(mem_valid),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .at_idle(at_idle), .in_burst(in_burst)
);

// File: tb/test_lkcache.sv
`timescale 1ns/100ps
module test_lkcache;
  logic clk = 0, rst_n = 0, cache_on = 1, copy_back = 1;
  logic cpu_req = 0, cpu_we = 0, cpu_stall;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic lk_we = 0, lk_val = 0;
  logic [5:0] lk_set = 0;
  logic [1:0] lk_way = 0;
  logic mem_valid, mem_we, mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  int total = 0, bad = 0, nrd = 0, nwr = 0;

  always #2 clk = ~clk;

  lkcache i_lkcache (.*);

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rdmem(input logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    return mem.exists(k) ? mem[k] : {k[15:0] ^ 16'hA5C3, k[31:16]};
  endfunction

  always @(negedge clk) begin
    mem_ready = 0;
    if (mem_valid && ($urandom % 3 != 0)) begin
      mem_ready = 1;
      if (mem_we) begin mem[mem_addr] = mem_wdata; nwr++; end
      else begin mem_rdata = rdmem(mem_addr); nrd++; end
    end
  end

  // independent model of the cache state, built from the requirements
  logic [20:0] mt [4][64];
  bit mv [4][64], md [4][64], ml [4][64];
  int mage [4][64];
  logic [31:0] mdat [4][64][8];

  task automatic touch(input int s, input int h);
    for (int u = 0; u < 4; u++) if (mage[u][s] < mage[h][s]) mage[u][s]++;
    mage[h][s] = 0;
  endtask

  task automatic predict(input bit we, input logic [31:0] a, input logic [31:0] d,
                         output int erd, output int ewr, output logic [31:0] ed);
    int s = int'(a[10:5]), w = int'(a[4:2]), h = -1, v = -1;
    erd = 0; ewr = 0; ed = 0;
    if (!cache_on || a[31:16] >= 16'hFEFF) begin
      if (we) ewr = 1; else begin erd = 1; ed = rdmem(a); end
      return;
    end
    for (int u = 0; u < 4; u++) if (mv[u][s] && mt[u][s] == a[31:11]) h = u;
    if (h < 0) begin
      for (int u = 0; u < 4; u++)
        if (!ml[u][s] && (v < 0 || (mv[v][s] && (!mv[u][s] || mage[u][s] > mage[v][s])))) v = u;
      if (we && (!copy_back || v < 0)) begin ewr = 1; return; end
      if (v < 0) begin erd = 1; ed = rdmem(a); return; end
      ewr = (copy_back && mv[v][s] && md[v][s]) ? 8 : 0;
      erd = 8;
      for (int k = 0; k < 8; k++) mdat[v][s][k] = rdmem({a[31:5], k[2:0], 2'b00});
      mt[v][s] = a[31:11]; mv[v][s] = 1; md[v][s] = 0;
      h = v;
    end
    if (we) begin
      mdat[h][s][w] = d; md[h][s] = copy_back;
      if (!copy_back) ewr = 1;
    end else ed = mdat[h][s][w];
    touch(s, h);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d, input string req);
    int erd, ewr;
    logic [31:0] ed, got;
    predict(we, a, d, erd, ewr, ed);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; nrd = 0; nwr = 0;
    #1;
    while (cpu_stall) begin @(negedge clk); #1; end
    got = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0;
    if (!we) chk(got === ed, req, "load data", got, ed);
    chk(nrd == erd, req, "memory reads", nrd, erd);
    chk(nwr == ewr, req, "memory writes", nwr, ewr);
  endtask

  task automatic lock(input int s, input int w, input bit val);
    @(negedge clk);
    lk_we = 1; lk_set = 6'(s); lk_way = 2'(w); lk_val = val;
    @(negedge clk);
    lk_we = 0;
    ml[w][s] = val;
  endtask

  function automatic logic [31:0] ad(input int t, input int s, input int w);
    return (32'(t) << 11) | (32'(s) << 5) | (32'(w) << 2);
  endfunction

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(2024));
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 64; s++) begin
        mv[w][s] = 0; md[w][s] = 0; ml[w][s] = 0; mage[w][s] = w;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cpu_stall == 0, "R1", "stall after reset", cpu_stall, 0);
    chk(mem_valid == 0, "R1", "mem_valid after reset", mem_valid, 0);

    // R4 refill then hit
    access(0, ad(2, 0, 3), 0, "R4");
    access(0, ad(2, 0, 5), 0, "R4");
    // R5 copy-back store hit leaves memory alone
    access(1, ad(2, 0, 3), 32'hCAFE0001, "R5");
    chk(rdmem(ad(2, 0, 3)) != 32'hCAFE0001, "R5", "memory unchanged", rdmem(ad(2, 0, 3)), 0);
    access(0, ad(2, 0, 3), 0, "R5");
    // R6 copy-back store miss allocates
    access(1, ad(3, 0, 1), 32'h1234ABCD, "R6");
    access(0, ad(3, 0, 1), 0, "R6");
    // R9 LRU fill and eviction order
    access(0, ad(4, 0, 0), 0, "R9");
    access(0, ad(5, 0, 0), 0, "R9");
    access(0, ad(3, 0, 2), 0, "R9");
    access(0, ad(4, 0, 2), 0, "R9");
    access(0, ad(5, 0, 2), 0, "R9");
    // R8 dirty LRU victim (tag 2) written back in copy-back mode
    access(0, ad(6, 0, 0), 0, "R8");
    access(0, ad(2, 0, 3), 0, "R8");
    // R10/R11 lock all ways of set 1
    for (int t = 2; t < 6; t++) access(0, ad(t, 1, 0), 0, "R11");
    for (int w = 0; w < 4; w++) lock(1, w, 1);
    access(0, ad(9, 1, 4), 0, "R10");
    access(1, ad(9, 1, 4), 32'h0BADF00D, "R10");
    access(0, ad(3, 1, 7), 0, "R10");
    lock(1, 2, 0);
    access(0, ad(9, 1, 4), 0, "R11");
    // R2 cache disabled
    cache_on = 0;
    access(0, ad(3, 1, 7), 0, "R2");
    access(1, ad(3, 1, 6), 32'h55AA55AA, "R2");
    cache_on = 1;
    access(0, ad(3, 1, 7), 0, "R2");
    // R3 uncacheable range
    access(0, 32'hFF000010, 0, "R3");
    access(0, 32'hFF000010, 0, "R3");
    access(1, 32'hFEFF0000, 32'h77777777, "R3");
    access(0, 32'hFEFEFFFC, 0, "R3");
    // R7 write-through
    copy_back = 0;
    access(1, ad(9, 1, 1), 32'hDEAD0007, "R7");
    chk(rdmem(ad(9, 1, 1)) == 32'hDEAD0007, "R7", "memory updated", rdmem(ad(9, 1, 1)), 32'hDEAD0007);
    access(1, ad(12, 0, 1), 32'hDEAD0008, "R7");
    access(0, ad(12, 0, 1), 0, "R7");
    // R8 write-through drops dirty victim without writeback
    copy_back = 1;
    access(1, ad(13, 2, 0), 32'h13, "R8");
    for (int t = 14; t < 17; t++) access(0, ad(t, 2, 0), 0, "R8");
    copy_back = 0;
    access(0, ad(17, 2, 0), 0, "R8");
    copy_back = 1;

    for (int n = 0; n < 700; n++) begin
      int r = $urandom % 100;
      if (r < 6) copy_back = ~copy_back;
      else if (r < 9) cache_on = ~cache_on;
      else if (r < 14) lock($urandom % 2, $urandom % 4, $urandom % 2);
      else if (r < 18)
        access($urandom % 2, 32'hFF000000 | ($urandom & 32'h00FFFFFC), $urandom, "R3");
      else
        access($urandom % 2, ad(2 + $urandom % 6, $urandom % 2, $urandom % 8), $urandom, "R9");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule